// File: doc/BRIEF.md
# Host Port Slave with Strobe Synchronizer

This block gives an external host access to on-chip memory through an asynchronous, strobe-framed bus. A chip select and two data strobes are merged into one internal strobe. That strobe is synchronized into the system clock, and a state machine acts on its start and end. At the start of a host cycle the block captures the access type, direction, half select, byte enables and (in direct mode) the address. At the end of the cycle it captures write data. On the internal side it issues single-word requests over a request/acknowledge port. The block holds a control register, which carries a sticky error bit, and an address register that can step forward by one word after each data access.

Three bus modes are chosen by a static mode input:
- **Multiplexed half-word:** 16-bit transfers, with the low half first.
- **Multiplexed fullword:** the address is loaded through the address register.
- **Direct fullword:** the address comes on its own bus, and only two access types are allowed.

The ready output tells the host to wait while an internal access is outstanding.

The state machine has six states:
- `ST_IDLE`: waits for the strobe.
- `ST_SKIP`: a rejected access; the block waits out the strobe.
- `ST_RD_REQ`: an internal read is in flight.
- `ST_RD_HOLD`: read data is driven until the strobe ends.
- `ST_WR_WAIT`: waits for the strobe end, when write data is taken.
- `ST_WR_REQ`: an internal write is in flight.

Transitions:
- From `ST_IDLE` on strobe start: to `ST_SKIP` (illegal code), `ST_WR_WAIT` (write), `ST_RD_REQ` (data read that needs memory) or `ST_RD_HOLD` (register read or second-half read).
- `ST_RD_REQ` goes to `ST_RD_HOLD` on acknowledge.
- `ST_RD_HOLD` and `ST_SKIP` go to `ST_IDLE` on strobe end.
- `ST_WR_WAIT` goes on strobe end to `ST_WR_REQ` (data write, full word ready) or else to `ST_IDLE`.
- `ST_WR_REQ` goes to `ST_IDLE` on acknowledge.

Top module: `hostport_slave`

## Requirements
- R1: The internal strobe is active only when `h_cs_n` is low and exactly one of `h_ds1_n`/`h_ds2_n` is low. Both strobes low, both high, or chip select high starts no cycle.
- R2: Access type, direction, half select and byte enables are taken at strobe start. Write data is taken at strobe end.
- R3: `h_acc` codes: 2'b00 control register, 2'b01 data with address step, 2'b10 address register, 2'b11 data without step.
- R4: `mode_sel` 2'b00 is multiplexed half-word, 2'b01 is multiplexed fullword, and 2'b1x is direct fullword, which takes the data address from `h_addr_in`.
- R5: In direct mode, codes 2'b01 and 2'b10 are rejected. A rejected access makes no memory request, does not change the address register or the error bit, and does not drive `h_doe`.
- R6: Control register bit 0 is a sticky error bit. It is set when a code-2'b01 access starts with address bits [1:0] not zero or with any `h_be_n` bit high. Writing 1 to bit 0 clears it; writing 0 leaves it.
- R7: `h_rdy` is high whenever `h_cs_n` is high.
- R8: In half-word mode, `h_hsel`=0 selects bits [15:0] and `h_hsel`=1 selects bits [31:16], both carried on `h_din`/`h_dout` [15:0]. A data write issues its memory request only after the second half. A data read issues its request on the first half; the second half returns the upper half of that same word without a new request.
- R9: After each completed fullword access with code 2'b01, the address register grows by 4. Code 2'b11 leaves it unchanged.
- R10: `h_rdy` is low (with chip select low) while a memory request is outstanding. Read data is driven with `h_doe` high from acknowledge until strobe end, never together with a request.
- R11: `m_req` stays high, with stable address, direction and write data, until `m_ack`. It drops on the cycle after `m_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| mode_sel | input | 2 | Bus mode (static between accesses) |
| h_cs_n | input | 1 | Host chip select, active low |
| h_ds1_n | input | 1 | Host data strobe 1 |
| h_ds2_n | input | 1 | Host data strobe 2 |
| h_rnw | input | 1 | 1 read, 0 write |
| h_acc | input | 2 | Access type code |
| h_hsel | input | 1 | Half select in half-word mode |
| h_be_n | input | 4 | Byte enables, active low |
| h_addr_in | input | 32 | Address bus in direct mode |
| h_din | input | 32 | Host write data |
| h_dout | output | 32 | Host read data |
| h_doe | output | 1 | Read data drive enable |
| h_rdy | output | 1 | Ready, low means wait |
| m_req | output | 1 | Memory request |
| m_we | output | 1 | Memory write enable |
| m_addr | output | MEM_AW | Memory byte address |
| m_wdata | output | 32 | Memory write data |
| m_be | output | 4 | Memory byte enables |
| m_rdata | input | 32 | Memory read data |
| m_ack | input | 1 | Memory acknowledge |

## Verification
A strobe start reaches the state machine three clock edges after it is driven: two synchronizer flops and the state register. So ready cannot fall before that point, and the host model waits four cycles before it first samples `h_rdy`, then polls until it rises. Read data is sampled in the same cycle that ready returns. Write data is taken three edges after the strobe ends, so the host model holds `h_din` for four cycles afterwards. Memory requests are compared against a queue filled by the host model just before the access that should produce them; a request with an empty queue is a failure.

// File: rtl/hps_pkg.sv
package hps_pkg;
    localparam int WORD_W    = 32;
    localparam int HALF_W    = WORD_W / 2;
    localparam int BE_W      = WORD_W / 8;
    localparam int WORD_STEP = BE_W;

    typedef enum logic [1:0] {
        ACC_CTRL     = 2'b00,
        ACC_DATA_INC = 2'b01,
        ACC_ADDR     = 2'b10,
        ACC_DATA_FIX = 2'b11
    } acc_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SKIP,
        ST_RD_REQ,
        ST_RD_HOLD,
        ST_WR_WAIT,
        ST_WR_REQ
    } hps_state_e;
endpackage

// File: rtl/hps_strobe_sync.sv
module hps_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic ds1_n,
    input  logic ds2_n,
    output logic strb_s
);
    logic             strb_raw;
    logic [STAGES-1:0] chain;

    // active when selected and exactly one data strobe is low
    assign strb_raw = !cs_n && (ds1_n ^ ds2_n);

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[0] <= 1'b0;
                else        chain[0] <= strb_raw;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[i] <= 1'b0;
                else        chain[i] <= chain[i-1];
            end
        end
    end

    assign strb_s = chain[STAGES-1];
endmodule

// File: rtl/hps_host_regs.sv
module hps_host_regs
    import hps_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_wr,
    input  logic [1:0]        addr_half_en,
    input  logic [WORD_W-1:0] addr_wdata,
    input  logic              addr_inc,
    input  logic              err_set,
    input  logic              err_clr,
    output logic [WORD_W-1:0] addr_q,
    output logic              err_q
);
    logic [WORD_W-1:0] wr_mask;
    logic [WORD_W-1:0] addr_next;

    for (genvar h = 0; h < 2; h++) begin : g_half
        assign wr_mask[h*HALF_W +: HALF_W] = {HALF_W{addr_half_en[h]}};
    end

    always_comb begin
        addr_next = addr_q;
        if (addr_inc)
            addr_next = addr_q + WORD_W'(WORD_STEP);
        else if (addr_wr)
            addr_next = (addr_q & ~wr_mask) | (addr_wdata & wr_mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            err_q  <= 1'b0;
        end else begin
            addr_q <= addr_next;
            if (err_set)      err_q <= 1'b1;
            else if (err_clr) err_q <= 1'b0;
        end
    end
endmodule

// File: rtl/hps_ctrl_fsm.sv
module hps_ctrl_fsm
    import hps_pkg::*;
#(
    parameter int MEM_AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strb_s,
    input  logic [1:0]        mode_sel,
    input  logic [1:0]        h_acc,
    input  logic              h_rnw,
    input  logic              h_hsel,
    input  logic [BE_W-1:0]   h_be_n,
    input  logic [WORD_W-1:0] h_din,
    input  logic [WORD_W-1:0] h_addr_in,
    input  logic [WORD_W-1:0] hpia,
    input  logic              err,
    input  logic [WORD_W-1:0] m_rdata,
    input  logic              m_ack,
    output logic              m_req,
    output logic              m_we,
    output logic [MEM_AW-1:0] m_addr,
    output logic [WORD_W-1:0] m_wdata,
    output logic [BE_W-1:0]   m_be,
    output logic [WORD_W-1:0] h_dout,
    output logic              h_doe,
    output logic              rdy_int,
    output logic              addr_wr,
    output logic [1:0]        addr_half_en,
    output logic [WORD_W-1:0] addr_wdata,
    output logic              addr_inc,
    output logic              err_set,
    output logic              err_clr
);
    hps_state_e state, nxt;

    logic              cap_half, cap_hsel;
    acc_e              cap_acc;
    logic [BE_W-1:0]   cap_be_n;
    logic [WORD_W-1:0] cap_addr;
    logic [WORD_W-1:0] rd_word_q, dout_q, wr_word_q;
    logic [HALF_W-1:0] wr_lo_q;

    logic half_mode, direct_mode, start, illegal, upper_rd, wr_end;
    logic [WORD_W-1:0] reg_rd_val;

    assign half_mode   = (mode_sel == 2'b00);
    assign direct_mode = mode_sel[1];
    assign start       = (state == ST_IDLE) && strb_s;
    assign illegal     = direct_mode &&
                         (h_acc == ACC_DATA_INC || h_acc == ACC_ADDR);
    assign upper_rd    = half_mode && h_hsel;
    assign wr_end      = (state == ST_WR_WAIT) && !strb_s;

    // value returned at strobe start for reads that need no memory access
    always_comb begin
        reg_rd_val = '0;
        unique case (acc_e'(h_acc))
            ACC_CTRL: if (!upper_rd) reg_rd_val[0] = err;
            ACC_ADDR: begin
                if (!half_mode)   reg_rd_val = hpia;
                else if (h_hsel)  reg_rd_val[HALF_W-1:0] = hpia[WORD_W-1:HALF_W];
                else              reg_rd_val[HALF_W-1:0] = hpia[HALF_W-1:0];
            end
            default: reg_rd_val[HALF_W-1:0] = rd_word_q[WORD_W-1:HALF_W];
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (strb_s) begin
                    if (illegal)                     nxt = ST_SKIP;
                    else if (!h_rnw)                 nxt = ST_WR_WAIT;
                    else if (h_acc[0] && !upper_rd)  nxt = ST_RD_REQ;
                    else                             nxt = ST_RD_HOLD;
                end
            end
            ST_SKIP:    if (!strb_s) nxt = ST_IDLE;
            ST_RD_REQ:  if (m_ack)   nxt = ST_RD_HOLD;
            ST_RD_HOLD: if (!strb_s) nxt = ST_IDLE;
            ST_WR_WAIT: begin
                if (!strb_s) begin
                    if (cap_acc[0] && !(cap_half && !cap_hsel)) nxt = ST_WR_REQ;
                    else                                        nxt = ST_IDLE;
                end
            end
            ST_WR_REQ:  if (m_ack)   nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // capture path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_half  <= 1'b0;
            cap_hsel  <= 1'b0;
            cap_acc   <= ACC_CTRL;
            cap_be_n  <= '0;
            cap_addr  <= '0;
            rd_word_q <= '0;
            dout_q    <= '0;
            wr_word_q <= '0;
            wr_lo_q   <= '0;
        end else begin
            if (start) begin
                cap_half <= half_mode;
                cap_hsel <= h_hsel;
                cap_acc  <= acc_e'(h_acc);
                cap_be_n <= h_be_n;
                cap_addr <= direct_mode ? h_addr_in : hpia;
                if (h_rnw && !illegal && !(h_acc[0] && !upper_rd))
                    dout_q <= reg_rd_val;
            end
            if (state == ST_RD_REQ && m_ack) begin
                rd_word_q <= m_rdata;
                dout_q    <= cap_half ? {{HALF_W{1'b0}}, m_rdata[HALF_W-1:0]} : m_rdata;
            end
            if (wr_end && cap_acc[0]) begin
                if (cap_half && !cap_hsel)
                    wr_lo_q <= h_din[HALF_W-1:0];
                else
                    wr_word_q <= cap_half ? {h_din[HALF_W-1:0], wr_lo_q} : h_din;
            end
        end
    end

    // outputs
    always_comb begin
        m_req        = (state == ST_RD_REQ) || (state == ST_WR_REQ);
        m_we         = (state == ST_WR_REQ);
        m_addr       = cap_addr[MEM_AW-1:0];
        m_wdata      = wr_word_q;
        m_be         = ~cap_be_n;
        h_dout       = dout_q;
        h_doe        = (state == ST_RD_HOLD);
        rdy_int      = !((state == ST_RD_REQ) || (state == ST_WR_REQ));
        addr_wr      = wr_end && (cap_acc == ACC_ADDR);
        addr_half_en = cap_half ? (cap_hsel ? 2'b10 : 2'b01) : 2'b11;
        addr_wdata   = cap_half ? {2{h_din[HALF_W-1:0]}} : h_din;
        err_clr      = wr_end && (cap_acc == ACC_CTRL) &&
                       !(cap_half && cap_hsel) && h_din[0];
        err_set      = start && !illegal && (h_acc == ACC_DATA_INC) &&
                       ((hpia[1:0] != 2'b00) || (h_be_n != '0));
        addr_inc     = (state == ST_RD_REQ && m_ack && cap_acc == ACC_DATA_INC && !cap_half)
                    || (state == ST_WR_REQ && m_ack && cap_acc == ACC_DATA_INC)
                    || (start && h_rnw && !illegal && h_acc == ACC_DATA_INC && upper_rd);
    end
endmodule

// File: rtl/hostport_slave.sv
module hostport_slave
    import hps_pkg::*;
#(
    parameter int MEM_AW      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_sel,
    input  logic              h_cs_n,
    input  logic              h_ds1_n,
    input  logic              h_ds2_n,
    input  logic              h_rnw,
    input  logic [1:0]        h_acc,
    input  logic              h_hsel,
    input  logic [3:0]        h_be_n,
    input  logic [31:0]       h_addr_in,
    input  logic [31:0]       h_din,
    output logic [31:0]       h_dout,
    output logic              h_doe,
    output logic              h_rdy,
    output logic              m_req,
    output logic              m_we,
    output logic [MEM_AW-1:0] m_addr,
    output logic [31:0]       m_wdata,
    output logic [3:0]        m_be,
    input  logic [31:0]       m_rdata,
    input  logic              m_ack
);
    logic              strb_s, rdy_int;
    logic [WORD_W-1:0] hpia;
    logic              err;
    logic              addr_wr, addr_inc, err_set, err_clr;
    logic [1:0]        addr_half_en;
    logic [WORD_W-1:0] addr_wdata;

    hps_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (h_cs_n),
        .ds1_n  (h_ds1_n),
        .ds2_n  (h_ds2_n),
        .strb_s (strb_s)
    );

    hps_ctrl_fsm #(.MEM_AW(MEM_AW)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .strb_s       (strb_s),
        .mode_sel     (mode_sel),
        .h_acc        (h_acc),
        .h_rnw        (h_rnw),
        .h_hsel       (h_hsel),
        .h_be_n       (h_be_n),
        .h_din        (h_din),
        .h_addr_in    (h_addr_in),
        .hpia         (hpia),
        .err          (err),
        .m_rdata      (m_rdata),
        .m_ack        (m_ack),
        .m_req        (m_req),
        .m_we         (m_we),
        .m_addr       (m_addr),
        .m_wdata      (m_wdata),
        .m_be         (m_be),
        .h_dout       (h_dout),
        .h_doe        (h_doe),
        .rdy_int      (rdy_int),
        .addr_wr      (addr_wr),
        .addr_half_en (addr_half_en),
        .addr_wdata   (addr_wdata),
        .addr_inc     (addr_inc),
        .err_set      (err_set),
        .err_clr      (err_clr)
    );

    hps_host_regs u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr_wr      (addr_wr),
        .addr_half_en (addr_half_en),
        .addr_wdata   (addr_wdata),
        .addr_inc     (addr_inc),
        .err_set      (err_set),
        .err_clr      (err_clr),
        .addr_q       (hpia),
        .err_q        (err)
    );

    // wait is only shown to a selected host
    assign h_rdy = h_cs_n | rdy_int;
endmodule

// File: rtl/hps_checks.sv
module hps_checks #(
    parameter int MEM_AW = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode_sel,
    input logic              h_cs_n,
    input logic              h_rdy,
    input logic              h_doe,
    input logic              m_req,
    input logic              m_ack,
    input logic              m_we,
    input logic [MEM_AW-1:0] m_addr,
    input logic [31:0]       m_wdata,
    input logic [31:0]       hpia
);
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !m_ack) |=> (m_req && $stable(m_addr) && $stable(m_we) && $stable(m_wdata)));

    p_req_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && m_ack) |=> !m_req);

    p_busy_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !h_cs_n) |-> !h_rdy);

    p_drive_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        h_doe |-> !m_req);

    p_direct_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel[1] && $past(mode_sel[1])) |-> $stable(hpia));
endmodule

bind hostport_slave hps_checks #(.MEM_AW(MEM_AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_sel (mode_sel),
    .h_cs_n   (h_cs_n),
    .h_rdy    (h_rdy),
    .h_doe    (h_doe),
    .m_req    (m_req),
    .m_ack    (m_ack),
    .m_we     (m_we),
    .m_addr   (m_addr),
    .m_wdata  (m_wdata),
    .hpia     (hpia)
);

// File: tb/sim_hostport_slave.sv
module sim_hostport_slave;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  mode_sel;
    logic        h_cs_n, h_ds1_n, h_ds2_n, h_rnw, h_hsel;
    logic [1:0]  h_acc;
    logic [3:0]  h_be_n;
    logic [31:0] h_addr_in, h_din, h_dout;
    logic        h_doe, h_rdy;
    logic        m_req, m_we, m_ack;
    logic [31:0] m_addr, m_wdata, m_rdata;
    logic [3:0]  m_be;

    always #5 clk = ~clk;

    hostport_slave u0 (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
        .h_cs_n(h_cs_n), .h_ds1_n(h_ds1_n), .h_ds2_n(h_ds2_n),
        .h_rnw(h_rnw), .h_acc(h_acc), .h_hsel(h_hsel), .h_be_n(h_be_n),
        .h_addr_in(h_addr_in), .h_din(h_din), .h_dout(h_dout),
        .h_doe(h_doe), .h_rdy(h_rdy),
        .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
        .m_be(m_be), .m_rdata(m_rdata), .m_ack(m_ack)
    );

    typedef struct packed {
        logic        we;
        logic [31:0] addr;
        logic [31:0] data;
        logic [3:0]  be;
    } mreq_t;

    mreq_t       exp_q[$];
    string       tag_q[$];
    int          n_chk = 0;
    int          n_bad = 0;
    logic        finished = 1'b0;
    logic [31:0] mem [16];

    localparam logic [1:0] C_CTRL = 2'b00, C_INC = 2'b01, C_ADDR = 2'b10, C_FIX = 2'b11;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic expect_req(input logic we, input logic [31:0] a, input logic [31:0] d,
                              input logic [3:0] be, input string tag);
        mreq_t e;
        e.we = we; e.addr = a; e.data = d; e.be = be;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // memory model and scoreboard monitor
    initial begin
        m_ack   = 1'b0;
        m_rdata = '0;
        for (int i = 0; i < 16; i++) mem[i] = '0;
        forever begin
            @(negedge clk);
            if (rst_n && m_req && !m_ack) begin
                if (h_cs_n) check("R7 ready while deselected", {31'b0, h_rdy}, 32'd1);
                if (exp_q.size() == 0) begin
                    n_chk++; n_bad++;
                    $display("FAIL R5/R8 unexpected request actual=%h expected=none", m_addr);
                end else begin
                    mreq_t e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    n_chk++;
                    if (m_we !== e.we || m_addr !== e.addr ||
                        (e.we && (m_wdata !== e.data || m_be !== e.be))) begin
                        n_bad++;
                        $display("FAIL %s actual=%b/%h/%h/%b expected=%b/%h/%h/%b",
                                 t, m_we, m_addr, m_wdata, m_be, e.we, e.addr, e.data, e.be);
                    end
                end
                repeat (2) @(negedge clk);
                if (m_we) begin
                    for (int b = 0; b < 4; b++)
                        if (m_be[b]) mem[m_addr[5:2]][b*8 +: 8] = m_wdata[b*8 +: 8];
                end else begin
                    m_rdata = mem[m_addr[5:2]];
                end
                m_ack = 1'b1;
                @(negedge clk);
                m_ack = 1'b0;
            end
        end
    end

    task automatic host_cycle(input logic rnw, input logic [1:0] acc, input logic hsel,
                              input logic [3:0] be_n, input logic [31:0] din,
                              input logic [31:0] ain, output logic [31:0] dout,
                              output logic oe, output logic busy);
        @(negedge clk);
        h_rnw = rnw; h_acc = acc; h_hsel = hsel; h_be_n = be_n;
        h_din = din; h_addr_in = ain;
        h_cs_n = 1'b0; h_ds1_n = 1'b0; h_ds2_n = 1'b1;
        repeat (4) @(negedge clk);
        busy = !h_rdy;
        while (!h_rdy) @(negedge clk);
        dout = h_dout;
        oe   = h_doe;
        h_ds1_n = 1'b1; h_cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] acc, input logic hsel, input logic [3:0] be_n,
                      input logic [31:0] din, input logic [31:0] ain);
        logic [31:0] d; logic oe; logic busy;
        host_cycle(1'b0, acc, hsel, be_n, din, ain, d, oe, busy);
    endtask

    task automatic rd(input logic [1:0] acc, input logic hsel, input logic [31:0] ain,
                      output logic [31:0] d, output logic oe, output logic busy);
        host_cycle(1'b1, acc, hsel, 4'b0000, 32'h0, ain, d, oe, busy);
    endtask

    initial begin
        logic [31:0] d;
        logic oe, busy;
        rst_n = 1'b0; mode_sel = 2'b01;
        h_cs_n = 1'b1; h_ds1_n = 1'b1; h_ds2_n = 1'b1; h_rnw = 1'b1;
        h_acc = 2'b00; h_hsel = 1'b0; h_be_n = 4'h0; h_addr_in = '0; h_din = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("reset ready", {31'b0, h_rdy}, 32'd1);
        check("reset oe", {31'b0, h_doe}, 32'd0);
        check("reset req", {31'b0, m_req}, 32'd0);

        // multiplexed fullword (R4)
        rd(C_CTRL, 0, 0, d, oe, busy); check("R3 R6 control reset", d, 32'h0);
        rd(C_ADDR, 0, 0, d, oe, busy); check("R3 address reset", d, 32'h0);
        wr(C_ADDR, 0, 4'h0, 32'h10, 0);
        rd(C_ADDR, 0, 0, d, oe, busy); check("R3 address write", d, 32'h10);
        expect_req(1, 32'h10, 32'hA5A50001, 4'hF, "R3 fixed write");
        wr(C_FIX, 0, 4'h0, 32'hA5A50001, 0);
        expect_req(0, 32'h10, 0, 4'hF, "R3 fixed read");
        rd(C_FIX, 0, 0, d, oe, busy);
        check("R3 fixed read data", d, 32'hA5A50001);
        check("R10 read drive", {31'b0, oe}, 32'd1);
        check("R10 wait during read", {31'b0, busy}, 32'd1);
        rd(C_ADDR, 0, 0, d, oe, busy); check("R9 fixed keeps address", d, 32'h10);

        expect_req(1, 32'h10, 32'h11111111, 4'hF, "R9 step write 0");
        wr(C_INC, 0, 4'h0, 32'h11111111, 0);
        expect_req(1, 32'h14, 32'h22222222, 4'hF, "R9 step write 1");
        wr(C_INC, 0, 4'h0, 32'h22222222, 0);
        rd(C_ADDR, 0, 0, d, oe, busy); check("R9 address after steps", d, 32'h18);
        rd(C_CTRL, 0, 0, d, oe, busy); check("R6 no error aligned", d, 32'h0);
        wr(C_ADDR, 0, 4'h0, 32'h10, 0);
        expect_req(0, 32'h10, 0, 4'hF, "R9 step read");
        rd(C_INC, 0, 0, d, oe, busy); check("R9 step read data", d, 32'h11111111);
        rd(C_ADDR, 0, 0, d, oe, busy); check("R9 address after read", d, 32'h14);

        // error bit
        wr(C_ADDR, 0, 4'h0, 32'h22, 0);
        expect_req(1, 32'h22, 32'h33, 4'hF, "R6 misaligned write");
        wr(C_INC, 0, 4'h0, 32'h33, 0);
        rd(C_CTRL, 0, 0, d, oe, busy); check("R6 misaligned sets error", d, 32'h1);
        rd(C_ADDR, 0, 0, d, oe, busy); check("R9 misaligned step", d, 32'h26);
        wr(C_CTRL, 0, 4'h0, 32'h1, 0);
        rd(C_CTRL, 0, 0, d, oe, busy); check("R6 clear by one", d, 32'h0);
        wr(C_ADDR, 0, 4'h0, 32'h20, 0);
        expect_req(1, 32'h20, 32'h44, 4'b1110, "R6 partial enables write");
        wr(C_INC, 0, 4'b0001, 32'h44, 0);
        rd(C_CTRL, 0, 0, d, oe, busy); check("R6 enables set error", d, 32'h1);
        wr(C_CTRL, 0, 4'h0, 32'h0, 0);
        rd(C_CTRL, 0, 0, d, oe, busy); check("R6 zero write keeps", d, 32'h1);
        wr(C_CTRL, 0, 4'h0, 32'h1, 0);
        rd(C_CTRL, 0, 0, d, oe, busy); check("R6 cleared again", d, 32'h0);

        // half-word mode (R4, R8)
        @(negedge clk); mode_sel = 2'b00;
        wr(C_ADDR, 0, 4'h0, 32'h0030, 0);
        wr(C_ADDR, 1, 4'h0, 32'h0000, 0);
        rd(C_ADDR, 0, 0, d, oe, busy); check("R8 address low half", d, 32'h0030);
        rd(C_ADDR, 1, 0, d, oe, busy); check("R8 address high half", d, 32'h0000);
        wr(C_INC, 0, 4'h0, 32'hBEEF, 0);
        expect_req(1, 32'h30, 32'hCAFEBEEF, 4'hF, "R8 joined write");
        wr(C_INC, 1, 4'h0, 32'hCAFE, 0);
        rd(C_ADDR, 0, 0, d, oe, busy); check("R9 half step", d, 32'h0034);
        wr(C_ADDR, 0, 4'h0, 32'h0030, 0);
        expect_req(0, 32'h30, 0, 4'hF, "R8 half read");
        rd(C_FIX, 0, 0, d, oe, busy); check("R8 first half read", d, 32'h0000BEEF);
        rd(C_FIX, 1, 0, d, oe, busy); check("R8 second half read", d, 32'h0000CAFE);
        expect_req(0, 32'h30, 0, 4'hF, "R8 half step read");
        rd(C_INC, 0, 0, d, oe, busy); check("R8 step first half", d, 32'h0000BEEF);
        rd(C_INC, 1, 0, d, oe, busy); check("R8 step second half", d, 32'h0000CAFE);
        rd(C_ADDR, 0, 0, d, oe, busy); check("R9 half read step", d, 32'h0034);

        // direct mode (R4, R5)
        @(negedge clk); mode_sel = 2'b10;
        expect_req(1, 32'h08, 32'h5A5A5A5A, 4'hF, "R4 direct write");
        wr(C_FIX, 0, 4'h0, 32'h5A5A5A5A, 32'h08);
        expect_req(0, 32'h08, 0, 4'hF, "R4 direct read");
        rd(C_FIX, 0, 32'h08, d, oe, busy); check("R4 direct read data", d, 32'h5A5A5A5A);
        wr(C_ADDR, 0, 4'h0, 32'h3C, 0);
        wr(C_INC, 0, 4'b0001, 32'h77, 32'h0E);
        rd(C_INC, 0, 32'h0C, d, oe, busy); check("R5 rejected read no drive", {31'b0, oe}, 32'd0);
        rd(C_ADDR, 0, 0, d, oe, busy); check("R5 rejected address read", {31'b0, oe}, 32'd0);
        rd(C_CTRL, 0, 0, d, oe, busy); check("R5 error untouched", d, 32'h0);
        @(negedge clk); mode_sel = 2'b01;
        rd(C_ADDR, 0, 0, d, oe, busy); check("R5 address untouched", d, 32'h34);

        // R1: both strobes low, then deselected single strobe
        @(negedge clk); h_cs_n = 1'b0; h_ds1_n = 1'b0; h_ds2_n = 1'b0; h_rnw = 1'b1;
        repeat (6) @(negedge clk);
        check("R1 both strobes no drive", {31'b0, h_doe}, 32'd0);
        h_cs_n = 1'b1; h_ds2_n = 1'b1;
        repeat (6) @(negedge clk);
        check("R1 deselected no drive", {31'b0, h_doe}, 32'd0);
        check("R7 ready deselected", {31'b0, h_rdy}, 32'd1);
        h_ds1_n = 1'b1;
        repeat (3) @(negedge clk);

        // R2: control at start, data at end (second strobe used here)
        h_rnw = 1'b0; h_acc = C_ADDR; h_hsel = 1'b0; h_din = 32'h0BAD;
        h_cs_n = 1'b0; h_ds2_n = 1'b0;
        repeat (5) @(negedge clk);
        h_acc = C_CTRL; h_din = 32'h40;
        @(negedge clk);
        h_ds2_n = 1'b1; h_cs_n = 1'b1;
        repeat (5) @(negedge clk);
        rd(C_ADDR, 0, 0, d, oe, busy); check("R2 capture edges", d, 32'h40);

        repeat (10) @(negedge clk);
        check("R5 R8 no outstanding expected requests", exp_q.size(), 32'd0);
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule